// File: doc/BRIEF.md
# Flash Row Programming Write Controller

This block holds one row of pending program-memory data and commits it to a behavioural flash array. Software sets a table pointer, then issues table writes. Each table write places one byte into a holding buffer, at the slot that the low pointer bits select. The pointer can step forward after each write, but only inside the current row.

Nothing reaches the array until a keyed start sequence arrives on a small register port: write-enable, the two key bytes, then the start bit. The block then stalls the processor for a fixed, parameterised number of cycles. During that window it walks the row and replaces every array byte with the old byte ANDed with the matching holding byte. The write therefore only clears bits. A holding byte left at 0xFF protects its array byte, so a single byte can be changed without loading the whole row. At the end the block raises a one-cycle done pulse and sets the buffer back to all-ones.

Top module: `flash_row_prog`

## Requirements
- R1: After reset, `stall`, `done`, `ctrl_rd` and `ptr_out` are all zero, and every holding byte is 0xFF. A commit made with no table writes leaves the target row unchanged.
- R2: A table write (`tw_valid`) stores `tw_data` into the holding byte selected by `ptr_out[IDX_W-1:0]`. The byte stays there until a long write completes, even if start attempts are rejected in between.
- R3: When `tw_incr` is set with a table write, the low IDX_W pointer bits step by one and wrap from ROW_BYTES-1 to 0. The row bits `ptr_out[PTR_W-1:IDX_W]` never change through increment.
- R4: A long write starts only after this exact chain of register writes, with no other register write between its steps. (1) A control write (`reg_sel`=0) with bit 0 (write-enable) set. (2) A key write (`reg_sel`=1) of 0x55. (3) A key write of 0xAA. (4) A control write with bit 0 and bit 1 (start) both set. `stall` is high in the cycle after step 4.
- R5: A wrong key value, or a control write placed between the key bytes, returns the sequence to its start. A start that follows is then ignored: `stall` stays low and the array is unchanged.
- R6: A key of 0x55 written while write-enable is clear does not arm the sequence. A later 0xAA and start are ignored.
- R7: `stall` stays high for exactly TIMER_CYCLES cycles. `ctrl_rd[1]` (write in progress) is 1 throughout that window and 0 afterwards. `ctrl_rd[0]` shows write-enable.
- R8: `done` is high for exactly one cycle, the first cycle after `stall` falls.
- R9: The committed row is `ptr_out[PTR_W-1:IDX_W]` at the start write. Each byte of that row becomes old AND holding byte. Other rows are untouched.
- R10: After a long write every holding byte is 0xFF again, so a second commit with no loads changes nothing.
- R11: While `stall` is high, table writes, pointer loads and register writes are ignored. The pointer and the buffer keep their values.
- R12: `rd_data` returns the array byte at `rd_addr` one cycle after the address is presented, whenever `stall` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load table pointer from `ptr_val` |
| ptr_val | input | PTR_W | New table pointer value |
| tw_valid | input | 1 | Table write strobe |
| tw_incr | input | 1 | Step pointer low bits after this table write |
| tw_data | input | 8 | Byte for the holding buffer |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = key register |
| reg_wdata | input | 8 | Register write data (control: bit 0 enable, bit 1 start) |
| rd_addr | input | PTR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |
| ptr_out | output | PTR_W | Current table pointer |
| ctrl_rd | output | 2 | {write in progress, write-enable} |
| stall | output | 1 | Processor stall during the long write |
| done | output | 1 | One-cycle pulse when the write finishes |

## Verification
The bench builds the block with 16 rows of 64 bytes and TIMER_CYCLES set to 80. That keeps each long write short, so a few dozen commits fit in the run, yet the timer still exceeds ROW_BYTES+1 as the row walk needs. Because the row is the full 64 bytes, the wrap from the last slot back to slot 0 is exercised at its real width. With 16 rows, random row picks also show whether a commit leaks into another row. TIMER_CYCLES must always be greater than ROW_BYTES+1.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic       SEL_CTRL   = 1'b0;
  localparam logic       SEL_KEY    = 1'b1;
  localparam int         BIT_WEN    = 0;
  localparam int         BIT_START  = 1;

  typedef enum logic [1:0] {
    UL_IDLE,
    UL_HALF,
    UL_ARMED
  } unlock_st_t;
endpackage

// File: rtl/fp_unlock.sv
module fp_unlock
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic       wen,
  output logic       start
);
  unlock_st_t st;

  // start is combinational so the long write begins on the same edge
  assign start = reg_we && !busy && (reg_sel == SEL_CTRL) && (st == UL_ARMED)
                 && reg_wdata[BIT_START] && reg_wdata[BIT_WEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= UL_IDLE;
      wen <= 1'b0;
    end else if (reg_we && !busy) begin
      if (reg_sel == SEL_KEY) begin
        unique case (st)
          UL_IDLE: st <= (wen && reg_wdata == KEY_FIRST) ? UL_HALF : UL_IDLE;
          UL_HALF: st <= (reg_wdata == KEY_SECOND) ? UL_ARMED : UL_IDLE;
          default: st <= UL_IDLE;
        endcase
      end else begin
        wen <= reg_wdata[BIT_WEN];
        st  <= UL_IDLE;
      end
    end
  end
endmodule

// File: rtl/fp_hold_buf.sv
module fp_hold_buf #(
  parameter int ROW_BYTES = 64,
  parameter int PTR_W     = 10,
  localparam int IDX_W    = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             busy,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             tw_valid,
  input  logic             tw_incr,
  input  logic [7:0]       tw_data,
  input  logic [IDX_W-1:0] sel_idx,
  output logic [7:0]       sel_byte,
  output logic [PTR_W-1:0] ptr
);
  logic [7:0] hb [ROW_BYTES];

  assign sel_byte = hb[sel_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < ROW_BYTES; i++) hb[i] <= 8'hFF;
    end else if (tw_valid && !busy) begin
      hb[ptr[IDX_W-1:0]] <= tw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (!busy) begin
      if (ptr_load) begin
        ptr <= ptr_val;
      end else if (tw_valid && tw_incr) begin
        ptr[IDX_W-1:0] <= ptr[IDX_W-1:0] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_array.sv
module fp_array #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog #(
  parameter int ROWS         = 16,
  parameter int ROW_BYTES    = 64,
  parameter int TIMER_CYCLES = 100,
  localparam int IDX_W = $clog2(ROW_BYTES),
  localparam int ROW_W = $clog2(ROWS),
  localparam int PTR_W = ROW_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             tw_valid,
  input  logic             tw_incr,
  input  logic [7:0]       tw_data,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr_out,
  output logic [1:0]       ctrl_rd,
  output logic             stall,
  output logic             done
);
  localparam int CW = $clog2(TIMER_CYCLES + 1);
  localparam int XW = IDX_W + 1;

  logic             busy, wen, start, finish, commit_we;
  logic [CW-1:0]    cnt;
  logic [XW-1:0]    idx;
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] widx;
  logic [7:0]       hold_byte, arr_q;
  logic [PTR_W-1:0] ra;

  fp_unlock u_unlock (
    .clk(clk), .rst(rst), .busy(busy), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .wen(wen), .start(start)
  );

  assign finish = busy && (cnt == CW'(TIMER_CYCLES - 1));
  assign widx   = IDX_W'(idx - 1'b1);

  fp_hold_buf #(.ROW_BYTES(ROW_BYTES), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .rst(rst), .clr(finish), .busy(busy), .ptr_load(ptr_load),
    .ptr_val(ptr_val), .tw_valid(tw_valid), .tw_incr(tw_incr), .tw_data(tw_data),
    .sel_idx(widx), .sel_byte(hold_byte), .ptr(ptr_out)
  );

  // Row walk: read slot idx, write slot idx-1 one cycle later
  assign commit_we = busy && (idx != '0) && (idx <= XW'(ROW_BYTES));
  assign ra        = busy ? {row, idx[IDX_W-1:0]} : rd_addr;

  fp_array #(.DEPTH(ROWS * ROW_BYTES)) u_arr (
    .clk(clk), .we(commit_we), .waddr({row, widx}), .wdata(arr_q & hold_byte),
    .raddr(ra), .rdata(arr_q)
  );

  assign rd_data = arr_q;
  assign stall   = busy;
  assign ctrl_rd = {busy, wen};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      row  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        idx  <= '0;
        row  <= ptr_out[PTR_W-1:IDX_W];
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (idx <= XW'(ROW_BYTES)) idx <= idx + 1'b1;
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_row_prog_chk.sv
module flash_row_prog_chk
  import flash_prog_pkg::*;
#(
  parameter int ROWS         = 16,
  parameter int ROW_BYTES    = 64,
  parameter int TIMER_CYCLES = 100,
  localparam int IDX_W = $clog2(ROW_BYTES),
  localparam int ROW_W = $clog2(ROWS),
  localparam int PTR_W = ROW_W + IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ptr_load,
  input logic             tw_valid,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [7:0]       reg_wdata,
  input logic [PTR_W-1:0] ptr_out,
  input logic [1:0]       ctrl_rd,
  input logic             stall,
  input logic             done
);
  localparam int RW = $clog2(TIMER_CYCLES + 1) + 1;
  logic [RW-1:0] run_c;

  always_ff @(posedge clk) begin
    if (rst)        run_c <= '0;
    else if (stall) run_c <= run_c + 1'b1;
    else            run_c <= '0;
  end

  p_stall_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> run_c == RW'(TIMER_CYCLES));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> run_c < RW'(TIMER_CYCLES));
  p_wr_flag_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> ctrl_rd[1]);
  p_done_after_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_start_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(reg_we && reg_sel == SEL_CTRL && reg_wdata[1:0] == 2'b11));
  p_row_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && !ptr_load) |=> ptr_out[PTR_W-1:IDX_W] == $past(ptr_out[PTR_W-1:IDX_W]));
  p_frozen_ptr_r11: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(ptr_out));
endmodule

bind flash_row_prog flash_row_prog_chk #(
  .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .TIMER_CYCLES(TIMER_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .ptr_load(ptr_load), .tw_valid(tw_valid), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ptr_out(ptr_out), .ctrl_rd(ctrl_rd),
  .stall(stall), .done(done)
);

// File: tb/flash_row_prog_test.sv
module flash_row_prog_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int RB   = 64;
  localparam int TMR  = 80;
  localparam int IW   = 6;
  localparam int PW   = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ptr_load = 0, tw_valid = 0, tw_incr = 0, reg_we = 0, reg_sel = 0;
  logic [PW-1:0] ptr_val = '0, rd_addr = '0;
  logic [7:0] tw_data = '0, reg_wdata = '0, rd_data;
  logic [PW-1:0] ptr_out;
  logic [1:0] ctrl_rd;
  logic stall, done;

  int n_tests = 0, n_fail = 0;
  logic [7:0] mem_m [ROWS*RB];
  logic [7:0] buf_m [RB];
  logic [PW-1:0] ptr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_row_prog #(.ROWS(ROWS), .ROW_BYTES(RB), .TIMER_CYCLES(TMR)) uut (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_val(ptr_val), .tw_valid(tw_valid),
    .tw_incr(tw_incr), .tw_data(tw_data), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .ptr_out(ptr_out),
    .ctrl_rd(ctrl_rd), .stall(stall), .done(done)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] and_bytes(logic [7:0] a, logic [7:0] b);
    return a & b;
  endfunction

  task automatic set_ptr(int row, int off);
    ptr_val = PW'(row * RB + off); ptr_load = 1;
    @(negedge clk); ptr_load = 0;
    ptr_m = PW'(row * RB + off);
  endtask

  task automatic tw_put(logic [7:0] d, logic inc);
    tw_data = d; tw_incr = inc; tw_valid = 1;
    @(negedge clk); tw_valid = 0; tw_incr = 0;
    buf_m[ptr_m[IW-1:0]] = d;
    if (inc) ptr_m[IW-1:0] = ptr_m[IW-1:0] + 1'b1;
  endtask

  task automatic reg_wr(logic sel, logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  // full keyed sequence; commit model; timing checks
  task automatic long_write(bit inject);
    int n = 0;
    int row = int'(ptr_m[PW-1:IW]);
    reg_wr(1'b0, 8'h01); reg_wr(1'b1, 8'h55); reg_wr(1'b1, 8'hAA); reg_wr(1'b0, 8'h03);
    chk("R4 stall after start", stall, 1);
    chk("R7 wr flag during write", ctrl_rd[1], 1);
    while (stall && n < TMR + 10) begin
      n++;
      if (inject && n == 2) begin
        tw_data = 8'h00; tw_incr = 1; tw_valid = 1;
        ptr_val = '0; ptr_load = 1;
        @(negedge clk); tw_valid = 0; tw_incr = 0; ptr_load = 0;
      end else @(negedge clk);
    end
    chk("R7 stall length", n, TMR);
    chk("R8 done on first low cycle", done, 1);
    if (inject) chk("R11 pointer frozen", ptr_out, ptr_m);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
    chk("R7 wr flag cleared", ctrl_rd, 2'b01);
    for (int i = 0; i < RB; i++) begin
      mem_m[row*RB+i] = and_bytes(mem_m[row*RB+i], buf_m[i]);
      buf_m[i] = 8'hFF;
    end
  endtask

  task automatic check_row(int row, string req);
    logic bad = 0;
    logic [7:0] a = 0, e = 0;
    for (int i = 0; i < RB; i++) begin
      rd_addr = PW'(row * RB + i);
      @(negedge clk);
      if (!bad && rd_data !== mem_m[row*RB+i]) begin
        bad = 1; a = rd_data; e = mem_m[row*RB+i];
      end
    end
    chk(req, a, e);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < ROWS*RB; i++) mem_m[i] = 8'hFF;
    for (int i = 0; i < RB; i++) buf_m[i] = 8'hFF;
    ptr_m = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 stall reset", stall, 0);
    chk("R1 done reset", done, 0);
    chk("R1 ctrl reset", ctrl_rd, 0);
    chk("R1 ptr reset", ptr_out, 0);

    // R1 / R10: commit with empty buffer leaves row erased
    set_ptr(3, 5);
    long_write(0);
    check_row(3, "R1 empty buffer commit (R12 read path)");

    // R2 / R9: directed AND commit
    set_ptr(5, 0);
    tw_put(8'hA5, 1); tw_put(8'h3C, 1);
    set_ptr(5, 32); tw_put(8'h00, 0);
    long_write(0);
    check_row(5, "R9 row 5 AND commit");
    check_row(4, "R9 neighbour row untouched");
    set_ptr(5, 0); tw_put(8'h5A, 0);
    long_write(0);
    check_row(5, "R9 clear-only second commit");
    long_write(0);
    check_row(5, "R10 buffer back to FF");

    // R3: wrap of the low bits
    set_ptr(7, 62);
    tw_put(8'h11, 1); tw_put(8'h22, 1); tw_put(8'h33, 1);
    chk("R3 wrap keeps row", ptr_out, PW'(7*RB + 1));
    long_write(0);
    check_row(7, "R3 wrapped bytes committed");

    // R5 / R6: rejected start sequences
    set_ptr(9, 10); tw_put(8'h0F, 1); tw_put(8'hF0, 1);
    reg_wr(1'b0, 8'h01); reg_wr(1'b1, 8'h55); reg_wr(1'b1, 8'h12);
    reg_wr(1'b1, 8'hAA); reg_wr(1'b0, 8'h03);
    chk("R5 wrong key ignored", stall, 0);
    reg_wr(1'b0, 8'h01); reg_wr(1'b1, 8'h55); reg_wr(1'b0, 8'h01);
    reg_wr(1'b1, 8'hAA); reg_wr(1'b0, 8'h03);
    chk("R5 intervening write ignored", stall, 0);
    reg_wr(1'b0, 8'h00); reg_wr(1'b1, 8'h55); reg_wr(1'b1, 8'hAA); reg_wr(1'b0, 8'h03);
    chk("R6 no enable ignored", stall, 0);
    reg_wr(1'b0, 8'h00);
    chk("R7 enable readback clear", ctrl_rd, 2'b00);
    check_row(9, "R5 array untouched");
    long_write(0);
    check_row(9, "R2 buffer retained across rejects");

    // R11: table write and pointer load during write
    set_ptr(11, 0); tw_put(8'h77, 0);
    long_write(1);
    check_row(11, "R11 busy table write ignored");

    // random rows and contents
    for (int it = 0; it < 14; it++) begin
      int row = int'($urandom % ROWS);
      int cnt = int'($urandom % 24) + 1;
      set_ptr(row, int'($urandom % RB));
      for (int k = 0; k < cnt; k++) tw_put(8'($urandom), 1'($urandom % 4 != 0));
      long_write(0);
      check_row(row, "R9 random commit");
    end
    report();
  end
endmodule